// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block forms the status word a host sees when it reads a flash bank that is busy with an embedded program or erase. Each qualified read strobe takes a snapshot of the operation context: the kind of operation, whether it has finished or failed, whether erase is suspended, whether the addressed sector belongs to the erase, the true data for the addressed location, and the sector-erase window timer. From that snapshot it returns either the true data or a coded status word. Two toggle bits advance once per read, never per clock.

The status word uses fixed bit positions, because host polling software decodes them. Bit 7 is the polling bit. Bit 6 is the main toggle. Bit 5 is the timeout flag. Bit 3 is the erase-window flag. Bit 2 is the erase toggle. All other bits of a status word read 0. A combinational ready output tells the system whether an embedded operation is actively running.

Top module: `flash_wstat`

## Requirements
- R1: After reset `stat_q` is 0, `stat_vld` is 0 and both toggle bits are 0, so the first toggling read after reset returns 1 in that toggle bit.
- R2: A read during a program (`op_kind`=1, not done) returns bit 7 = inverse of `true_data[7]`, bit 5 = `op_fail`, and bits 4, 3, 1 and 0 = 0.
- R3: Bit 6 inverts on each read taken during a program or an unsuspended erase. A strobe held high for several clocks counts as one read.
- R4: A read during an unsuspended erase (`op_kind`=2, `erase_susp`=0, not done) returns bit 7 = 0, bit 5 = `op_fail`, bit 3 = `win_closed`, and bits 4, 1 and 0 = 0.
- R5: Bit 2 inverts on a read during an unsuspended erase only when `in_erase_sector` is 1. It keeps its value on reads during a program and on erase reads of other sectors.
- R6: A read of an erase-suspended sector (`op_kind`=2, `erase_susp`=1, `in_erase_sector`=1) returns bit 7 = 1, bit 6 unchanged, bit 2 inverted, and all other bits 0. `rdy` is 1 in this state.
- R7: The read returns `true_data` unchanged, and neither toggle bit moves, in each of these cases: `op_done` is 1; `op_kind` is 0 or 3; a suspended erase is read at a sector outside the erase.
- R8: A program issued while erase is suspended (`op_kind`=1, `erase_susp`=1) returns the same status as a normal program (R2, R3, R5).
- R9: `stat_vld` is high for exactly one cycle, in the cycle after the clock edge at which a rising `rd_stb` is first sampled. `stat_q` holds its value between reads.
- R10: `rdy` is 0 while a program, or an unsuspended erase, is in progress and not done. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_kind | input | 2 | 0 none, 1 program, 2 erase, 3 treated as none |
| erase_susp | input | 1 | Erase is suspended |
| op_done | input | 1 | Embedded operation has completed |
| op_fail | input | 1 | Operation exceeded its time limit |
| in_erase_sector | input | 1 | Addressed sector is part of the erase |
| true_data | input | DW | Data being programmed, or array data at the address |
| win_closed | input | 1 | Sector-erase command window has closed |
| rd_stb | input | 1 | Read strobe for the busy bank |
| stat_q | output | DW | Value returned for the last read |
| stat_vld | output | 1 | One-cycle pulse marking a new `stat_q` |
| rdy | output | 1 | High when no embedded operation is actively running |

## Verification
A rising read strobe is sampled at clock edge N. The new `stat_q` and the `stat_vld` pulse appear after edge N, so the monitor compares them at the falling edge that follows edge N. The driver holds the operation context steady until after edge N and only then releases the strobe. It returns the strobe low for at least one edge before the next read. `rdy` is combinational, so the driver checks it one time unit after it changes the context. Toggle expectations come from the bench's own count of qualifying reads, which is how held strobes and reads that leave the toggles alone are caught.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    CL_TRUE  = 2'd0,
    CL_PROG  = 2'd1,
    CL_ERASE = 2'd2,
    CL_SUSP  = 2'd3
  } cls_e;

  localparam int BIT_POLL = 7;
  localparam int BIT_TGL  = 6;
  localparam int BIT_TMO  = 5;
  localparam int BIT_WIN  = 3;
  localparam int BIT_ETGL = 2;

  // index of each toggle inside the toggle vector
  localparam int TG_MAIN  = 0;
  localparam int TG_ERASE = 1;
  localparam int TG_N     = 2;

  function automatic cls_e classify(input op_e op, input logic susp,
                                    input logic done, input logic insec);
    cls_e c;
    c = CL_TRUE;
    if (!done) begin
      case (op)
        OP_PROG:  c = CL_PROG;
        OP_ERASE: begin
          if (!susp)      c = CL_ERASE;
          else if (insec) c = CL_SUSP;
          else            c = CL_TRUE;
        end
        default:  c = CL_TRUE;
      endcase
    end
    return c;
  endfunction

  function automatic logic main_flips(input cls_e c);
    return (c == CL_PROG) || (c == CL_ERASE);
  endfunction

  function automatic logic erase_flips(input cls_e c, input logic insec);
    return (c == CL_SUSP) || ((c == CL_ERASE) && insec);
  endfunction

  function automatic logic is_busy(input op_e op, input logic susp,
                                   input logic done);
    return !done && ((op == OP_PROG) || ((op == OP_ERASE) && !susp));
  endfunction

endpackage

// File: rtl/fws_edge.sv
module fws_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strobe;
  end

  assign rise = strobe && !prev_q;
endmodule

// File: rtl/fws_class.sv
module fws_class
  import flash_wstat_pkg::*;
(
  input  logic [1:0] op_kind,
  input  logic       susp,
  input  logic       done,
  input  logic       insec,
  output cls_e       cls,
  output logic [TG_N-1:0] flip
);
  op_e op;

  always_comb begin
    op  = op_e'(op_kind);
    cls = classify(op, susp, done, insec);
    flip = '0;
    flip[TG_MAIN]  = main_flips(cls);
    flip[TG_ERASE] = erase_flips(cls, insec);
  end
endmodule

// File: rtl/fws_toggle.sv
module fws_toggle #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [N-1:0] flip,
  output logic [N-1:0] state,
  output logic [N-1:0] nxt
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic bit_q;
    assign nxt[g]   = bit_q ^ (adv && flip[g]);
    assign state[g] = bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= nxt[g];
    end
  end
endmodule

// File: rtl/fws_encode.sv
module fws_encode
  import flash_wstat_pkg::*;
#(
  parameter int DW = 8
) (
  input  cls_e          cls,
  input  logic [DW-1:0] data,
  input  logic          fail,
  input  logic          win,
  input  logic [TG_N-1:0] tgl,
  output logic [DW-1:0] value
);
  always_comb begin
    value = '0;
    unique case (cls)
      CL_TRUE: value = data;
      CL_PROG: begin
        value[BIT_POLL] = ~data[BIT_POLL];
        value[BIT_TGL]  = tgl[TG_MAIN];
        value[BIT_TMO]  = fail;
        value[BIT_ETGL] = tgl[TG_ERASE];
      end
      CL_ERASE: begin
        value[BIT_POLL] = 1'b0;
        value[BIT_TGL]  = tgl[TG_MAIN];
        value[BIT_TMO]  = fail;
        value[BIT_WIN]  = win;
        value[BIT_ETGL] = tgl[TG_ERASE];
      end
      CL_SUSP: begin
        value[BIT_POLL] = 1'b1;
        value[BIT_TGL]  = tgl[TG_MAIN];
        value[BIT_ETGL] = tgl[TG_ERASE];
      end
    endcase
  end
endmodule

// File: rtl/flash_wstat.sv
module flash_wstat
  import flash_wstat_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op_kind,
  input  logic          erase_susp,
  input  logic          op_done,
  input  logic          op_fail,
  input  logic          in_erase_sector,
  input  logic [DW-1:0] true_data,
  input  logic          win_closed,
  input  logic          rd_stb,
  output logic [DW-1:0] stat_q,
  output logic          stat_vld,
  output logic          rdy
);
  localparam int MIN_DW = BIT_POLL + 1;

  logic            rd_rise;
  cls_e            cls;
  logic [TG_N-1:0] tgl_flip;
  logic [TG_N-1:0] tgl_state;
  logic [TG_N-1:0] tgl_next;
  logic [DW-1:0]   stat_d;

  initial begin
    if (DW < MIN_DW) $error("flash_wstat: DW too small");
  end

  fws_edge u_edge (
    .clk(clk), .rst_n(rst_n), .strobe(rd_stb), .rise(rd_rise)
  );

  fws_class u_class (
    .op_kind(op_kind), .susp(erase_susp), .done(op_done),
    .insec(in_erase_sector), .cls(cls), .flip(tgl_flip)
  );

  fws_toggle #(.N(TG_N)) u_tgl (
    .clk(clk), .rst_n(rst_n), .adv(rd_rise), .flip(tgl_flip),
    .state(tgl_state), .nxt(tgl_next)
  );

  fws_encode #(.DW(DW)) u_enc (
    .cls(cls), .data(true_data), .fail(op_fail), .win(win_closed),
    .tgl(tgl_next), .value(stat_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q   <= '0;
      stat_vld <= 1'b0;
    end else begin
      stat_vld <= rd_rise;
      if (rd_rise) stat_q <= stat_d;
    end
  end

  assign rdy = !is_busy(op_e'(op_kind), erase_susp, op_done);
endmodule

// File: rtl/flash_wstat_chk.sv
module flash_wstat_chk
  import flash_wstat_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      op_kind,
  input logic            op_done,
  input logic            erase_susp,
  input logic [DW-1:0]   true_data,
  input logic            win_closed,
  input logic            rdy,
  input logic [DW-1:0]   stat_q,
  input logic            stat_vld,
  input logic            rd_rise,
  input cls_e            cls,
  input logic [TG_N-1:0] tgl_state
);
  AST_VLD_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise |=> stat_vld) else $error("AST_VLD_AFTER_RISE"); // R9
  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |=> !stat_vld) else $error("AST_VLD_SINGLE"); // R9
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rise |=> $stable(stat_q)) else $error("AST_HOLD_BETWEEN"); // R9
  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise && cls == CL_PROG |=> stat_q[BIT_POLL] == !$past(true_data[BIT_POLL]))
    else $error("AST_PROG_POLL"); // R2
  AST_ERASE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise && cls == CL_ERASE |=> !stat_q[BIT_POLL] && stat_q[BIT_WIN] == $past(win_closed))
    else $error("AST_ERASE_FLAGS"); // R4
  AST_MAIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise && (cls == CL_PROG || cls == CL_ERASE) |=> tgl_state[TG_MAIN] != $past(tgl_state[TG_MAIN]))
    else $error("AST_MAIN_TOGGLE"); // R3
  AST_PROG_ETGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise && cls == CL_PROG |=> $stable(tgl_state[TG_ERASE]))
    else $error("AST_PROG_ETGL_HOLD"); // R5
  AST_SUSP_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise && cls == CL_SUSP |=> stat_q[BIT_POLL] && $stable(tgl_state[TG_MAIN]))
    else $error("AST_SUSP_POLL"); // R6
  AST_TRUE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise && cls == CL_TRUE |=> stat_q == $past(true_data) && $stable(tgl_state))
    else $error("AST_TRUE_DATA"); // R7
  AST_RDY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_kind == 2'd1 || (op_kind == 2'd2 && !erase_susp)) && !op_done |-> !rdy)
    else $error("AST_RDY_BUSY"); // R10
endmodule

bind flash_wstat flash_wstat_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .op_done(op_done),
  .erase_susp(erase_susp), .true_data(true_data), .win_closed(win_closed),
  .rdy(rdy), .stat_q(stat_q), .stat_vld(stat_vld), .rd_rise(rd_rise),
  .cls(cls), .tgl_state(tgl_state)
);

// File: tb/test_flash_wstat.sv
`timescale 1ns/1ps
module test_flash_wstat;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic       erase_susp = 1'b0, op_done = 1'b0, op_fail = 1'b0;
  logic       in_erase_sector = 1'b0, win_closed = 1'b0, rd_stb = 1'b0;
  logic [7:0] true_data = 8'h00;
  logic [7:0] stat_q;
  logic       stat_vld, rdy;

  int checks = 0, failures = 0;
  bit finished = 0;
  bit m6 = 0, m2 = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  flash_wstat #(.DW(8)) i_flash_wstat (
    .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .erase_susp(erase_susp),
    .op_done(op_done), .op_fail(op_fail), .in_erase_sector(in_erase_sector),
    .true_data(true_data), .win_closed(win_closed), .rd_stb(rd_stb),
    .stat_q(stat_q), .stat_vld(stat_vld), .rdy(rdy)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: set context, predict, push, strobe
  task automatic rd(input logic [1:0] op, input bit sp, input bit dn, input bit fl,
                    input bit ins, input logic [7:0] d, input bit wn,
                    input int hold, input string tag);
    logic [7:0] e;
    bit exp_rdy;
    op_kind = op; erase_susp = sp; op_done = dn; op_fail = fl;
    in_erase_sector = ins; true_data = d; win_closed = wn;
    #1;
    exp_rdy = !(!dn && (op == 2'd1 || (op == 2'd2 && !sp)));
    check(rdy == exp_rdy, "R10 rdy", {7'd0, rdy}, {7'd0, exp_rdy});
    if (dn || op == 2'd0 || op == 2'd3 || (op == 2'd2 && sp && !ins)) begin
      e = d;
    end else if (op == 2'd1) begin
      m6 = ~m6;
      e = {~d[7], m6, fl, 1'b0, 1'b0, m2, 2'b00};
    end else if (!sp) begin
      m6 = ~m6;
      if (ins) m2 = ~m2;
      e = {1'b0, m6, fl, 1'b0, wn, m2, 2'b00};
    end else begin
      m2 = ~m2;
      e = {1'b1, m6, 1'b0, 1'b0, 1'b0, m2, 2'b00};
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_stb = 1'b1;
    repeat (hold) @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && stat_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected stat_vld", stat_q, 8'h00);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(stat_q === e, t, stat_q, e);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(stat_q == 8'h00, "R1 reset stat_q", stat_q, 8'h00);
    check(stat_vld == 1'b0, "R1 reset stat_vld", {7'd0, stat_vld}, 8'h00);

    // program: first read shows toggle 1 after reset (R1)
    rd(2'd1, 0, 0, 0, 0, 8'hA5, 0, 1, "R1 R2 first program read");
    rd(2'd1, 0, 0, 0, 0, 8'hA5, 0, 1, "R2 R3 program read 2");
    rd(2'd1, 0, 0, 1, 0, 8'h3C, 1, 1, "R2 program timeout");
    // erase with sector in erase
    rd(2'd2, 0, 0, 0, 1, 8'hFF, 0, 1, "R4 R5 erase window open");
    rd(2'd2, 0, 0, 0, 1, 8'hFF, 1, 1, "R4 R5 erase window closed");
    rd(2'd2, 0, 0, 0, 0, 8'hFF, 1, 1, "R5 erase other sector");
    rd(2'd2, 0, 0, 1, 1, 8'h00, 1, 1, "R4 erase timeout");
    // held strobe counts once
    rd(2'd2, 0, 0, 0, 1, 8'hFF, 1, 4, "R3 held strobe");
    rd(2'd1, 0, 0, 0, 0, 8'h12, 0, 1, "R3 R5 after held strobe");
    // suspend
    rd(2'd2, 1, 0, 0, 1, 8'h77, 0, 1, "R6 suspended sector read");
    rd(2'd2, 1, 0, 0, 1, 8'h77, 0, 1, "R6 suspended sector read 2");
    rd(2'd2, 1, 0, 0, 0, 8'h5A, 0, 1, "R7 suspended other sector");
    rd(2'd1, 1, 0, 0, 0, 8'h81, 0, 1, "R8 program in suspend");
    rd(2'd1, 1, 0, 0, 0, 8'h01, 0, 1, "R8 program in suspend 2");
    // done / idle
    rd(2'd1, 0, 1, 0, 0, 8'hC3, 0, 1, "R7 program done");
    rd(2'd2, 0, 1, 0, 1, 8'hE7, 1, 1, "R7 erase done");
    rd(2'd0, 0, 0, 0, 0, 8'h99, 0, 1, "R7 idle");
    rd(2'd3, 0, 0, 0, 1, 8'h42, 0, 1, "R7 reserved op");
    rd(2'd2, 0, 0, 0, 1, 8'hFF, 0, 1, "R7 toggles resume after true reads");

    // stat_q holds with no strobe
    begin
      logic [7:0] held;
      held = stat_q;
      true_data = 8'h00; op_kind = 2'd1;
      repeat (3) @(negedge clk);
      check(stat_q == held && !stat_vld, "R9 hold between reads", stat_q, held);
    end

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all reads answered", 8'(exp_q.size()), 8'h00);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule